// File: doc/BRIEF.md
# Sync-Character Hunting Serial Receiver

This block takes in a synchronous serial bit stream and recovers character boundaries from it. A modem supplies the data line and a bit-clock enable. The enable is a one-cycle pulse in the system clock domain that marks each valid bit. While the receiver is hunting, it keeps an 8-bit window of the most recent bits. On every qualified bit it compares the whole window against a programmable sync byte. The window moves forward one bit per enable pulse until the comparison hits.

Once it has framing, the receiver counts off 8-bit groups. Each completed group is presented as a parallel character, least significant bit first on the line, together with a one-cycle valid pulse. After lock the stream has no start or stop bits, so every bit is data. A mode input can require two back-to-back sync bytes before lock, which lowers the chance of framing on a look-alike pattern. The consumer acknowledges each character with a read strobe. A sticky overrun flag records a character that arrived before the previous one was acknowledged. A hunt request puts the receiver back into search, for example at the start of a transmission or after a dropout.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset (rst_n low at a clock edge), the receiver is searching: locked=0, char_valid=0, overrun=0 and rx_char=0. The bit window is cleared to all zeros.
- R2: A bit is taken from rx_bit only at a clock edge where bit_en=1. Changes on rx_bit while bit_en=0 have no effect on the characters delivered.
- R3: In single-sync mode (dual_sync=0), locked rises in the cycle after the bit at which the last 8 received bits equal sync_pat. The window holds the oldest bit at bit 0 and the newest at bit 7, so the sync byte is sent LSB first. This holds at any bit offset from the start of the search.
- R4: The sync byte or bytes that achieve lock never produce char_valid. The first char_valid follows the 8th bit received after lock.
- R5: While locked, char_valid is a one-cycle pulse that follows every 8th received bit. At that pulse rx_char holds those 8 bits with the first-received bit at bit 0. After lock, bits equal to sync_pat are delivered as ordinary data.
- R6: In double-sync mode (dual_sync=1), lock is declared only if the 8 bits right after a first match also equal sync_pat. If they do not, the receiver stays in search and keeps comparing the sliding window on each later bit.
- R7: hunt_req=1 at a clock edge returns the receiver to search. It clears the window, locked and overrun, and overrides a bit_en in the same cycle.
- R8: If a character completes while the previous character has not been acknowledged by rd_ack, overrun is set. It stays set through later rd_ack pulses until hunt_req or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hunt_req | input | 1 | Force sync search, clears framing and overrun |
| dual_sync | input | 1 | 1 = two consecutive sync bytes needed for lock |
| sync_pat | input | 8 | Programmable sync byte |
| bit_en | input | 1 | One-cycle pulse qualifying rx_bit |
| rx_bit | input | 1 | Serial data line |
| rd_ack | input | 1 | Consumer has read the current character |
| rx_char | output | 8 | Last assembled character |
| char_valid | output | 1 | One-cycle pulse, new character in rx_char |
| locked | output | 1 | Framing achieved |
| overrun | output | 1 | Sticky: a character was lost |

## Verification
A wrong bit counter shows up at the ports within one character time: characters come out rotated, or char_valid arrives at a spacing other than eight bits. A stuck search state appears as locked never rising within 8 bits of a complete sync byte. A false match shows up as locked rising before the sync byte ends. A pending flag that is lost or stuck shows as overrun rising one character late or not at all. The sliding search is exercised at several preamble offsets. The failed second sync in double mode is followed directly by valid sync bytes, so the recovery must come from sliding the window, without a hunt request.

// File: rtl/sync_rx_pkg.sv
// Shared types for the sync-hunting receiver.
package sync_rx_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_FIRST = 2'd1,
        ST_LOCK  = 2'd2
    } hunt_state_t;
endpackage

// File: rtl/rx_shift_win.sv
// Serial-in window. The newest bit enters at the MSB and the oldest leaves at
// the LSB, so an LSB-first character lines up at its natural bit positions.
// Assumes shift is a single-cycle qualifier. clr takes priority over shift.
module rx_shift_win #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] win_next
);
    logic [W-1:0] win_q;

    // Window contents including the bit currently offered.
    always_comb win_next = {din, win_q[W-1:1]};

    // Window register: clear on reset or hunt, advance on a qualified bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            win_q <= '0;
        else if (shift)
            win_q <= win_next;
    end

    AST_WIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift && !clr) |=> $stable(win_q)); // R2
endmodule

// File: rtl/rx_frame_fsm.sv
// Framing control. It hunts for the sync byte, optionally confirms it with a
// second sync byte, then counts W-bit groups. Assumes win_next already
// includes the bit offered with shift. clr returns the FSM to hunting.
module rx_frame_fsm
    import sync_rx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         dual,
    input  logic [W-1:0] win_next,
    input  logic [W-1:0] pat,
    output logic         locked,
    output logic         grp_done
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    hunt_state_t   st_q;
    logic [CW-1:0] cnt_q;
    logic          hit;

    // Parallel compare of the sliding window against the sync byte.
    always_comb hit = (win_next == pat);

    // A group is complete on the last bit of a group while locked.
    always_comb grp_done = shift && !clr && (st_q == ST_LOCK) && (cnt_q == LAST);

    always_comb locked = (st_q == ST_LOCK);

    // State and bit counter update, one step per qualified bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st_q  <= ST_HUNT;
            cnt_q <= '0;
        end else if (shift) begin
            unique case (st_q)
                ST_HUNT: begin
                    if (hit) begin
                        st_q  <= dual ? ST_FIRST : ST_LOCK;
                        cnt_q <= '0;
                    end
                end
                ST_FIRST: begin
                    if (cnt_q == LAST) begin
                        st_q  <= hit ? ST_LOCK : ST_HUNT;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_LOCK: begin
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                end
                default: begin
                    st_q  <= ST_HUNT;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    AST_LOCK_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(shift)); // R3
    AST_CONFIRM_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(locked) && $past(dual)) |-> $past(st_q == ST_FIRST)); // R6
endmodule

// File: rtl/rx_char_hold.sv
// Character holding register with valid pulse and overrun detection.
// Assumes load is a single-cycle pulse per completed character. A character
// stays pending until rd_ack is seen. clr wipes pending and overrun.
module rx_char_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         rd_ack,
    output logic [W-1:0] data,
    output logic         valid,
    output logic         overrun
);
    logic pending_q;

    // Data register: capture each completed character.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data <= '0;
        else if (load && !clr)
            data <= din;
    end

    // Valid pulse, pending flag and sticky overrun.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            valid     <= 1'b0;
            pending_q <= 1'b0;
            overrun   <= 1'b0;
        end else if (load) begin
            valid     <= 1'b1;
            pending_q <= 1'b1;
            if (pending_q && !rd_ack)
                overrun <= 1'b1;
        end else begin
            valid <= 1'b0;
            if (rd_ack)
                pending_q <= 1'b0;
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R5
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr) |=> overrun); // R8
endmodule

// File: rtl/sync_hunt_rx.sv
// Top of the sync-hunting serial receiver. It wires the bit window, the
// framing FSM and the character holding register together. Assumes bit_en
// is a single-cycle pulse already in the clk domain and synchronous to rx_bit.
module sync_hunt_rx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hunt_req,
    input  logic         dual_sync,
    input  logic [W-1:0] sync_pat,
    input  logic         bit_en,
    input  logic         rx_bit,
    input  logic         rd_ack,
    output logic [W-1:0] rx_char,
    output logic         char_valid,
    output logic         locked,
    output logic         overrun
);
    logic [W-1:0] win_next;
    logic         grp_done;

    rx_shift_win #(.W(W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (hunt_req),
        .shift    (bit_en),
        .din      (rx_bit),
        .win_next (win_next)
    );

    rx_frame_fsm #(.W(W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (hunt_req),
        .shift    (bit_en),
        .dual     (dual_sync),
        .win_next (win_next),
        .pat      (sync_pat),
        .locked   (locked),
        .grp_done (grp_done)
    );

    rx_char_hold #(.W(W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (hunt_req),
        .load    (grp_done),
        .din     (win_next),
        .rd_ack  (rd_ack),
        .data    (rx_char),
        .valid   (char_valid),
        .overrun (overrun)
    );

    AST_VALID_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> locked); // R4
    AST_VALID_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> $past(bit_en && !hunt_req)); // R2
    AST_HUNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_req |=> (!locked && !overrun && !char_valid)); // R7
endmodule

// File: tb/sim_sync_hunt_rx.sv
module sim_sync_hunt_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hunt_req = 1'b0;
    logic       dual_sync = 1'b0;
    logic [7:0] sync_pat = 8'h16;
    logic       bit_en = 1'b0;
    logic       rx_bit = 1'b0;
    logic       rd_ack = 1'b0;
    logic [7:0] rx_char;
    logic       char_valid;
    logic       locked;
    logic       overrun;

    int n_chk = 0;
    int n_bad = 0;
    int cv_cnt = 0;
    logic [7:0] last_char = '0;

    always #10 clk = ~clk;

    sync_hunt_rx u0 (
        .clk(clk), .rst_n(rst_n), .hunt_req(hunt_req), .dual_sync(dual_sync),
        .sync_pat(sync_pat), .bit_en(bit_en), .rx_bit(rx_bit), .rd_ack(rd_ack),
        .rx_char(rx_char), .char_valid(char_valid), .locked(locked),
        .overrun(overrun)
    );

    // Vector: pattern, payload, dual flag, number of leading zero bits.
    localparam int NV = 4;
    localparam logic [23:0] VEC [NV] = '{
        {8'h16, 8'hA3, 4'd0, 4'd0},
        {8'h7E, 8'h3C, 4'd1, 4'd3},
        {8'hA5, 8'h0F, 4'd0, 4'd5},
        {8'h3C, 8'hF1, 4'd1, 4'd2}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_bit = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        if (char_valid) begin
            cv_cnt++;
            last_char = rx_char;
        end
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic hunt();
        @(negedge clk);
        hunt_req = 1'b1;
        @(negedge clk);
        hunt_req = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 locked", locked, 0);
        chk("R1 char_valid", char_valid, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 rx_char", rx_char, 0);
        rst_n = 1'b1;

        // Table-driven lock and delivery at several offsets.
        for (int v = 0; v < NV; v++) begin
            sync_pat  = VEC[v][23:16];
            dual_sync = VEC[v][4];
            hunt();
            cv_cnt = 0;
            for (int z = 0; z < int'(VEC[v][3:0]); z++) send_bit(1'b0);
            send_byte(VEC[v][23:16]);
            if (VEC[v][4]) begin
                chk("R6 not locked after one sync", locked, 0);
                send_byte(VEC[v][23:16]);
            end
            chk("R3 locked after sync", locked, 1);
            chk("R4 no char for sync", cv_cnt, 0);
            send_byte(VEC[v][15:8]);
            chk("R5 one char per byte", cv_cnt, 1);
            chk("R5 char value", last_char, VEC[v][15:8]);
        end

        // R6: failed confirmation, then sliding recovery without hunt_req.
        sync_pat = 8'h16; dual_sync = 1'b1;
        hunt();
        send_byte(8'h16);
        send_byte(8'h55);
        chk("R6 stays searching on bad second byte", locked, 0);
        send_byte(8'h16);
        chk("R6 one sync still not enough", locked, 0);
        send_byte(8'h16);
        chk("R6 lock after two syncs", locked, 1);

        // R5: sync-valued data is delivered while locked.
        cv_cnt = 0;
        send_byte(8'h16);
        chk("R5 sync value as data", last_char, 8'h16);
        chk("R5 still locked", locked, 1);
        ack();

        // R2: rx_bit wiggles without bit_en are ignored.
        cv_cnt = 0;
        for (int i = 0; i < 4; i++) send_bit(i == 0 || i == 3);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rx_bit = ~rx_bit;
        end
        for (int i = 4; i < 8; i++) send_bit(i >= 6);
        chk("R2 one char", cv_cnt, 1);
        chk("R2 char unaffected", last_char, 8'hC9);

        // R8: acknowledged sequence gives no overrun.
        ack();
        send_byte(8'h81);
        chk("R8 no overrun when acked", overrun, 0);
        send_byte(8'h42);
        chk("R8 overrun on unread char", overrun, 1);
        ack();
        chk("R8 overrun sticky after ack", overrun, 1);

        // R7: hunt request clears, and wins over a bit in the same cycle.
        @(negedge clk);
        hunt_req = 1'b1; bit_en = 1'b1; rx_bit = 1'b1;
        @(negedge clk);
        hunt_req = 1'b0; bit_en = 1'b0;
        chk("R7 unlocked", locked, 0);
        chk("R7 overrun cleared", overrun, 0);
        chk("R7 no char", char_valid, 0);
        dual_sync = 1'b0;
        send_byte(8'h16);
        chk("R7 relock from cleared window", locked, 1);

        // R1: reset while locked.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset unlocks", locked, 0);
        chk("R1 reset clears char", rx_char, 0);
        rst_n = 1'b1;

        finish_run();
    end
endmodule